// File: doc/BRIEF.md
# Video Acquisition Line Timing Generator

This block produces the per-line control strobes needed to capture digitised video into a field memory. It runs on the acquisition pixel clock and keeps a horizontal position counter. From that counter it decodes several outputs:

- a horizontal reference square wave;
- a clamp pulse for the analog front end;
- a composite write enable, built from a programmable horizontal window and an external vertical window;
- an input enable that can freeze the memory contents.

A clock enable at half the pixel rate is also provided.

Two line-timing sources are supported. In internal mode the counter runs freely with a programmable line length, and its horizontal reference output is what an external phase-locked loop locks the pixel clock to. In external mode, used when the video is already digital, a synchronised rising edge on an external reference input restarts the counter. Software programs the block through a small parallel write port. Every write lands in a staging copy, and the staged values move into the working set only when the counter restarts, so a pulse is never cut off in the middle of a line. Freeze mode holds the input enable low while the write enable keeps running. A strobe input overrides the freeze without being clocked, which lets an inset picture be written live into an otherwise frozen picture.

Top module: `acq_line_timer`

## Requirements
- R1: In internal mode (control bit 0 = 0) the counter counts 0 up to L-1 and then wraps, where L is the line length register (address 0). hRefOut is high while the counter is below L/2, so it rises on the cycle the counter is 0.
- R2: In external mode (control bit 0 = 1) the counter does not wrap at L. It counts up, stops at its maximum value, and restarts only on a detected rising edge of extRefIn.
- R3: halfClkEn is low during reset and inverts on every clock edge afterwards, so it is high in the first cycle after reset is released.
- R4: clampOut is high while the counter value c satisfies clampStart <= c < clampEnd (addresses 1 and 2). This holds in both modes.
- R5: weOut is the AND of the horizontal window weStart <= c < weEnd (addresses 3 and 4) and the vWinIn input.
- R6: Control bits [3:2] delay the horizontal window by 0, 1, 2 or 3 clock cycles before the AND with vWinIn.
- R7: With the freeze bit set (control bit 1 = 1) and strobeIn low, ieOut is low. weOut keeps its normal pattern while frozen.
- R8: strobeIn high forces ieOut high combinationally, with no clock involved.
- R9: A write to any register (control is address 5) takes effect only at the next counter restart. The line in progress finishes with the old values.
- R10: extRefIn passes through two synchroniser flops and one edge register. If extRefIn rises before clock edge k, the counter reads 0 after edge k+2.
- R11: After reset the counter is 0, L holds its default of 864, and all other registers are 0. hRefOut is therefore high, clampOut and weOut are low, and ieOut is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | 11 | Configuration write data |
| extRefIn | input | 1 | External horizontal reference (external mode) |
| vWinIn | input | 1 | Vertical write window |
| strobeIn | input | 1 | Asynchronous freeze override |
| hRefOut | output | 1 | Horizontal reference, 50% duty |
| clampOut | output | 1 | Clamp pulse |
| halfClkEn | output | 1 | Half-rate clock enable |
| weOut | output | 1 | Composite write enable |
| ieOut | output | 1 | Memory input enable |

## Verification
A 20-cycle line is captured cycle by cycle. The captured outputs are compared against window patterns that were derived independently. The vertical window is tried both open and closed, to show that the write enable really is gated by it. Each of the four fine delays is run in turn: a pattern shifted by the wrong number of cycles gives a different mismatch for each delay, so an off-by-one in the tap selection is caught. A mid-line rewrite of the clamp end checks that the change only appears from the next line. A long wait in external mode shows that the counter does not wrap. Stepping cycle by cycle after an edge on the external reference pins down the latency of the synchroniser.

// File: rtl/acq_line_pkg.sv
package acq_line_pkg;
  parameter int CNT_W   = 11;
  parameter int MAX_DLY = 3;
  localparam int DLY_W  = $clog2(MAX_DLY + 1);

  typedef enum logic [2:0] {
    A_LEN = 3'd0,
    A_CLS = 3'd1,
    A_CLE = 3'd2,
    A_WES = 3'd3,
    A_WEE = 3'd4,
    A_CTL = 3'd5
  } cfgAddr_e;

  typedef struct packed {
    logic [CNT_W-1:0] clampStart;
    logic [CNT_W-1:0] clampEnd;
    logic [CNT_W-1:0] weStart;
    logic [CNT_W-1:0] weEnd;
    logic             freeze;
    logic [DLY_W-1:0] weDelay;
  } dpCfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] lineLen;
    logic             extMode;
    dpCfg_t           dp;
  } lineCfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             hRefLvl;
  } ctlStrobe_t;
endpackage

// File: rtl/acq_line_ctrl.sv
module acq_line_ctrl
  import acq_line_pkg::*;
#(
  parameter int DEF_LEN     = 864,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             extRefIn,
  output dpCfg_t           dpCfg,
  output ctlStrobe_t       strb
);
  localparam lineCfg_t RESET_CFG = '{lineLen: CNT_W'(DEF_LEN), extMode: 1'b0, dp: '0};

  lineCfg_t shadow;
  lineCfg_t act;
  logic [CNT_W-1:0] cnt;
  logic [SYNC_STAGES:0] refSync;
  logic extEdge;
  logic wrapNow;
  logic [CNT_W-1:0] lastPos;
  logic [CNT_W-1:0] halfLen;

  // staging copy written by the configuration port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= RESET_CFG;
    end else if (cfgWrEn) begin
      case (cfgAddr_e'(cfgAddr))
        A_LEN: shadow.lineLen       <= cfgData;
        A_CLS: shadow.dp.clampStart <= cfgData;
        A_CLE: shadow.dp.clampEnd   <= cfgData;
        A_WES: shadow.dp.weStart    <= cfgData;
        A_WEE: shadow.dp.weEnd      <= cfgData;
        A_CTL: begin
          shadow.extMode    <= cfgData[0];
          shadow.dp.freeze  <= cfgData[1];
          shadow.dp.weDelay <= cfgData[2 +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  // synchroniser plus one edge register on the external reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else       refSync <= {refSync[SYNC_STAGES-1:0], extRefIn};
  end

  assign extEdge = refSync[SYNC_STAGES-1] & ~refSync[SYNC_STAGES];
  assign lastPos = act.lineLen - 1'b1;
  assign wrapNow = act.extMode ? extEdge : (cnt >= lastPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      act <= RESET_CFG;
    end else if (wrapNow) begin
      cnt <= '0;
      act <= shadow;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign halfLen      = act.lineLen >> 1;
  assign dpCfg        = act.dp;
  assign strb.cnt     = cnt;
  assign strb.hRefLvl = cnt < halfLen;
endmodule

// File: rtl/acq_line_dp.sv
module acq_line_dp
  import acq_line_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCfg_t     dpCfg,
  input  ctlStrobe_t strb,
  input  logic       vWinIn,
  input  logic       strobeIn,
  output logic       hRefOut,
  output logic       clampOut,
  output logic       halfClkEn,
  output logic       weOut,
  output logic       ieOut
);
  logic hWin;
  logic hWinDly;
  logic [MAX_DLY-1:0] dlyLine;
  logic halfReg;

  assign hWin = (strb.cnt >= dpCfg.weStart) && (strb.cnt < dpCfg.weEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyLine <= '0;
    else       dlyLine <= MAX_DLY'({dlyLine, hWin});
  end

  always_comb begin
    if (dpCfg.weDelay == '0) hWinDly = hWin;
    else                     hWinDly = dlyLine[dpCfg.weDelay - 1'b1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfReg <= 1'b0;
    else       halfReg <= ~halfReg;
  end

  assign hRefOut   = strb.hRefLvl;
  assign clampOut  = (strb.cnt >= dpCfg.clampStart) && (strb.cnt < dpCfg.clampEnd);
  assign halfClkEn = halfReg;
  assign weOut     = hWinDly & vWinIn;
  assign ieOut     = ~dpCfg.freeze | strobeIn;
endmodule

// File: rtl/acq_line_timer.sv
module acq_line_timer
  import acq_line_pkg::*;
#(
  parameter int DEF_LEN = 864
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             extRefIn,
  input  logic             vWinIn,
  input  logic             strobeIn,
  output logic             hRefOut,
  output logic             clampOut,
  output logic             halfClkEn,
  output logic             weOut,
  output logic             ieOut
);
  dpCfg_t     dpCfg;
  ctlStrobe_t strb;

  acq_line_ctrl #(.DEF_LEN(DEF_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .extRefIn(extRefIn), .dpCfg(dpCfg), .strb(strb)
  );

  acq_line_dp u_dp (
    .clk(clk), .rstN(rstN), .dpCfg(dpCfg), .strb(strb),
    .vWinIn(vWinIn), .strobeIn(strobeIn), .hRefOut(hRefOut),
    .clampOut(clampOut), .halfClkEn(halfClkEn), .weOut(weOut), .ieOut(ieOut)
  );
endmodule

// File: rtl/acq_line_timer_chk.sv
module acq_line_timer_chk
  import acq_line_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lineLen,
  input logic             extMode,
  input logic             freeze,
  input logic             extEdge,
  input lineCfg_t         actCfg,
  input logic             hRefOut,
  input logic             halfClkEn,
  input logic             weOut,
  input logic             vWinIn,
  input logic             ieOut,
  input logic             strobeIn
);
  p_href_at_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> hRefOut);

  p_int_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && (cnt >= lineLen - 1'b1)) |=> (cnt == '0));

  p_ext_no_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && !extEdge) |=> (cnt != '0));

  p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (halfClkEn != $past(halfClkEn)));

  p_we_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    weOut |-> vWinIn);

  p_freeze_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !strobeIn) |-> !ieOut);

  p_strobe_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn |-> ieOut);

  p_cfg_at_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actCfg) |-> (cnt == '0));

  p_ext_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && extEdge) |=> (cnt == '0));
endmodule

bind acq_line_timer acq_line_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .cnt(strb.cnt), .lineLen(u_ctrl.act.lineLen),
  .extMode(u_ctrl.act.extMode), .freeze(dpCfg.freeze), .extEdge(u_ctrl.extEdge),
  .actCfg(u_ctrl.act), .hRefOut(hRefOut), .halfClkEn(halfClkEn), .weOut(weOut),
  .vWinIn(vWinIn), .ieOut(ieOut), .strobeIn(strobeIn)
);

// File: tb/acq_line_timer_tb_top.sv
`timescale 1ns/1ps
module acq_line_timer_tb_top;
  localparam int L = 20;

  logic clk = 1'b0;
  logic rstN, cfgWrEn, extRefIn, vWinIn, strobeIn;
  logic [2:0] cfgAddr;
  logic [10:0] cfgData;
  logic hRefOut, clampOut, halfClkEn, weOut, ieOut;

  int nTests = 0;
  int nFail  = 0;
  logic [L-1:0] capH, capC, capW, capI;

  always #5 clk = ~clk;

  acq_line_timer dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .extRefIn(extRefIn), .vWinIn(vWinIn), .strobeIn(strobeIn), .hRefOut(hRefOut),
    .clampOut(clampOut), .halfClkEn(halfClkEn), .weOut(weOut), .ieOut(ieOut)
  );

  task automatic check(string req, logic [31:0] actual, logic [31:0] expected, string what);
    nTests++;
    if (actual !== expected) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, actual, expected);
    end
  endtask

  task automatic cfgWrite(logic [2:0] a, logic [10:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic syncLine();
    do @(negedge clk); while (hRefOut !== 1'b0);
    do @(negedge clk); while (hRefOut !== 1'b1);
  endtask

  task automatic captureLine();
    for (int i = 0; i < L; i++) begin
      capH[i] = hRefOut; capC[i] = clampOut; capW[i] = weOut; capI[i] = ieOut;
      @(negedge clk);
    end
  endtask

  function automatic logic [L-1:0] winVec(int lo, int hi, int d);
    logic [L-1:0] v;
    for (int i = 0; i < L; i++) v[i] = ((i - d) >= lo) && ((i - d) < hi);
    return v;
  endfunction

  task automatic testReset();
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0;
    extRefIn = 1'b0; vWinIn = 1'b1; strobeIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", hRefOut, 1, "hRefOut in reset");
    check("R11", clampOut, 0, "clampOut in reset");
    check("R11", weOut, 0, "weOut in reset");
    check("R11", ieOut, 1, "ieOut in reset");
    check("R3", halfClkEn, 0, "halfClkEn in reset");
    rstN = 1'b1;
  endtask

  task automatic testHalfClk();
    logic [7:0] got;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      got[i] = halfClkEn;
    end
    check("R3", got, 8'h55, "halfClkEn sequence after reset");
  endtask

  task automatic testBaseLine();
    cfgWrite(3'd0, 11'(L));
    cfgWrite(3'd1, 11'd2);
    cfgWrite(3'd2, 11'd5);
    cfgWrite(3'd3, 11'd4);
    cfgWrite(3'd4, 11'd10);
    cfgWrite(3'd5, 11'd0);
    syncLine();
    captureLine();
    check("R1", capH, winVec(0, L / 2, 0), "hRefOut line pattern");
    check("R4", capC, winVec(2, 5, 0), "clampOut line pattern");
    check("R5", capW, winVec(4, 10, 0), "weOut with window open");
    check("R7", capI, {L{1'b1}}, "ieOut not frozen");
    vWinIn = 1'b0;
    captureLine();
    check("R5", capW, '0, "weOut with window closed");
    check("R1", capH, winVec(0, L / 2, 0), "hRefOut second line wraps");
    vWinIn = 1'b1;
  endtask

  task automatic testDelays();
    for (int d = 1; d <= 3; d++) begin
      cfgWrite(3'd5, 11'(d << 2));
      syncLine();
      captureLine();
      check("R6", capW, winVec(4, 10, d), $sformatf("weOut delayed by %0d", d));
    end
  endtask

  task automatic testFreeze();
    cfgWrite(3'd5, 11'd2);
    syncLine();
    captureLine();
    check("R7", capI, '0, "ieOut frozen");
    check("R7", capW, winVec(4, 10, 0), "weOut runs while frozen");
    strobeIn = 1'b1;
    #1;
    check("R8", ieOut, 1, "strobe override, no clock");
    strobeIn = 1'b0;
    #1;
    check("R8", ieOut, 0, "strobe released");
    @(negedge clk);
  endtask

  task automatic testShadow();
    logic [L-1:0] tail;
    cfgWrite(3'd5, 11'd0);
    syncLine();
    repeat (6) @(negedge clk);
    cfgWrite(3'd2, 11'd8);
    tail = '0;
    for (int i = 7; i < L; i++) begin
      tail[i] = clampOut;
      @(negedge clk);
    end
    check("R9", tail, '0, "clamp unchanged mid-line");
    captureLine();
    check("R9", capC, winVec(2, 8, 0), "new clamp end on next line");
  endtask

  task automatic testExternal();
    int ones = 0;
    cfgWrite(3'd5, 11'd1);
    syncLine();
    for (int i = 0; i < 45; i++) begin
      ones += int'(hRefOut);
      @(negedge clk);
    end
    check("R2", ones, L / 2, "no wrap without external edge");
    check("R2", hRefOut, 0, "hRefOut low past line length");
    extRefIn = 1'b1;
    @(negedge clk);
    check("R10", hRefOut, 0, "restart not after one edge");
    @(negedge clk);
    check("R10", hRefOut, 0, "restart not after two edges");
    @(negedge clk);
    check("R10", hRefOut, 1, "restart after three edges");
    repeat (2) @(negedge clk);
    check("R4", clampOut, 1, "clamp at count 2 in external mode");
    repeat (40) @(negedge clk);
    check("R2", hRefOut, 0, "held-high reference makes no restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testHalfClk();
    testBaseLine();
    testDelays();
    testFreeze();
    testShadow();
    testExternal();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule